// File: doc/BRIEF.md
# Multi-Level Page Table Walker

This engine translates a 32-bit logical address into a physical address. It walks a chain of translation tables held in memory. A request carries the logical address, a translation control word and a two-word root pointer. The walker checks the root index against the root's bound, then reads one descriptor per level through a single-word read port. Each descriptor's type code decides what happens next. The walk can stop at a page descriptor, fault, or continue into a table whose entries are one word (short) or two words (long).

Flag bits from every descriptor visited are OR-combined into an attribute result. The offset mask shrinks by each level's index width. When the walk ends on a page descriptor, the physical address is the page frame with the surviving low logical bits merged in. The walker takes one request at a time and ends each request with a one-cycle `done_o` or `fault_o` pulse.

The controller has six states: `ST_IDLE`, `ST_RD0` (read descriptor word 0), `ST_RD1` (read descriptor word 1), `ST_DECODE`, `ST_DONE` and `ST_FAULT`.
- `ST_IDLE` moves on `start_i` to `ST_DONE` (translation off), to `ST_FAULT` (bad root), or to `ST_RD0`.
- `ST_RD0` moves on `mem_rvalid_i` to `ST_RD1` for a long entry and to `ST_DECODE` for a short one.
- `ST_RD1` moves on `mem_rvalid_i` to `ST_DECODE`.
- `ST_DECODE` moves to `ST_DONE` (page), to `ST_FAULT` (invalid entry, zero width or index out of bound) or back to `ST_RD0` (next table).
- `ST_DONE` and `ST_FAULT` return to `ST_IDLE` after one cycle.

Top module: `ptw_walker`

## Requirements
- R1: While reset is applied and in the first cycle after it, `done_o`, `fault_o` and `mem_req_o` are 0, and `paddr_o` and `attr_o` are 0.
- R2: If control bit 31 is 0 when a request starts, no memory read is made. `done_o` pulses in the cycle after the start, with `paddr_o` equal to the logical address and `attr_o` 0.
- R3: The root type is root word 0 bits 1:0. Type 0 or 1 raises `fault_o` in the cycle after the start, with no memory read.
- R4: Root word 0 bit 31 = 1 makes the 15-bit value in bits 30:16 a lower bound, with 0x7FFF as the upper bound. Bit 31 = 0 makes that value an upper bound, with 0 as the lower bound. An index outside the bounds faults. The entry offset is the index minus the lower bound.
- R5: The first index is the top W bits of the logical address shifted left by the initial shift. The initial shift is control bits 19:16; W is control bits 15:12. The root table base is root word 1 with bits 3:0 cleared. An entry address is base + offset×4 for a short table and base + offset×8 for a long table.
- R6: Descriptor type codes (bits 1:0 of word 0) are 0 invalid (fault), 1 page (walk ends), 2 table of short entries, 3 table of long entries. A long entry is read as two words at consecutive addresses, address then address+4.
- R7: In a short descriptor, the next table base is the word with bits 1:0 cleared and the page frame is the word with bits 7:0 cleared. Its attribute contribution is bits 7:2 for a page and bits 3:2 for a table.
- R8: In a long descriptor, word 1 carries the next table base (bits 1:0 cleared) or the page frame (bits 7:0 cleared). Its attribute contribution is word 0 bits 15:2.
- R9: A long table descriptor bounds the next index with its own word 0 bit 31 and bits 30:16, using the rule of R4.
- R10: Levels after the root take their index widths from control bits 11:8, then 7:4, then 3:0. A table descriptor whose next width is 0, or one found after the last width, faults.
- R11: The offset mask starts at all ones and is shifted right by the initial shift and by every consumed width. `paddr_o` is the frame OR (logical address AND mask).
- R12: `attr_o` is the OR of all contributions along the walk, and bit k of a contribution lands on `attr_o[k]`.
- R13: `done_o` and `fault_o` are never high together and each lasts one cycle. `paddr_o` and `attr_o` change only in a cycle where `done_o` is high. `start_i` is ignored unless the walker is idle.
- R14: `mem_req_o` stays high with a stable `mem_addr_o` until `mem_rvalid_i` is seen; data is taken in the cycle `mem_rvalid_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a translation (taken only when idle) |
| logical_addr_i | input | 32 | Logical address to translate |
| xlat_ctrl_i | input | 32 | Translation control word |
| root_w0_i | input | 32 | Root pointer word 0 (type, bound) |
| root_w1_i | input | 32 | Root pointer word 1 (table base) |
| mem_req_o | output | 1 | Descriptor read request |
| mem_addr_o | output | 32 | Byte address of the word requested |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data |
| done_o | output | 1 | One-cycle pulse: translation complete |
| fault_o | output | 1 | One-cycle pulse: translation failed |
| paddr_o | output | 32 | Translated physical address |
| attr_o | output | 14 | Accumulated descriptor attribute bits |

## Verification
A new request can arrive in the very cycle the walker reports completion, or while a walk is still reading memory. Either way the start must be lost, and it must not disturb the result being reported. The bench provokes both cases. It pulses `start_i` with a different address during a slow walk, and again in the cycle `done_o` is seen. It then judges that the reported address and attributes belong to the first request. It also checks that no further memory request appears after the completion pulse.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    localparam int VA_W              = 32;
    localparam int LIM_W             = 15;
    localparam int WID_W             = 4;
    localparam int ATTR_W            = 14;
    localparam int LEVELS_AFTER_ROOT = 3;

    typedef enum logic [1:0] {
        KIND_INVALID   = 2'd0,
        KIND_PAGE      = 2'd1,
        KIND_TBL_SHORT = 2'd2,
        KIND_TBL_LONG  = 2'd3
    } desc_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD0,
        ST_RD1,
        ST_DECODE,
        ST_DONE,
        ST_FAULT
    } walk_state_e;
endpackage

// File: rtl/ptw_desc_decode.sv
module ptw_desc_decode
    import ptw_pkg::*;
#(
    parameter int AW    = VA_W,
    parameter int LIMW  = LIM_W,
    parameter int ATTRW = ATTR_W
) (
    input  logic [AW-1:0]    word0_i,
    input  logic [AW-1:0]    word1_i,
    input  logic             long_fmt_i,
    output desc_kind_e       kind_o,
    output logic [AW-1:0]    frame_o,
    output logic [AW-1:0]    next_tbl_o,
    output logic [ATTRW-1:0] flags_o,
    output logic             lim_lower_o,
    output logic [LIMW-1:0]  lim_val_o
);
    localparam int FRAME_LSB = 8;
    localparam int NEXT_LSB  = 2;

    logic [AW-1:0] ptr_word;
    logic          ptr_unused;

    always_comb begin
        kind_o     = desc_kind_e'(word0_i[1:0]);
        ptr_word   = long_fmt_i ? word1_i : word0_i;
        frame_o    = {ptr_word[AW-1:FRAME_LSB], {FRAME_LSB{1'b0}}};
        next_tbl_o = {ptr_word[AW-1:NEXT_LSB], {NEXT_LSB{1'b0}}};
        if (long_fmt_i)
            flags_o = word0_i[ATTRW+1:2];
        else if (kind_o == KIND_PAGE)
            flags_o = ATTRW'(word0_i[FRAME_LSB-1:2]);
        else
            flags_o = ATTRW'(word0_i[3:2]);
        lim_lower_o = word0_i[AW-1];
        lim_val_o   = word0_i[AW-2 -: LIMW];
    end

    assign ptr_unused = ^ptr_word[NEXT_LSB-1:0];
endmodule

// File: rtl/ptw_index_unit.sv
module ptw_index_unit
    import ptw_pkg::*;
#(
    parameter int AW   = VA_W,
    parameter int LIMW = LIM_W,
    parameter int WW   = WID_W
) (
    input  logic [AW-1:0]   rem_i,
    input  logic [WW-1:0]   width_i,
    input  logic            check_i,
    input  logic            lower_i,
    input  logic [LIMW-1:0] limit_i,
    output logic [AW-1:0]   offset_o,
    output logic            in_range_o
);
    localparam int SHW = $clog2(AW) + 1;

    logic [SHW-1:0] sh;
    logic [AW-1:0]  idx;
    logic [AW-1:0]  lim_ext;
    logic [AW-1:0]  low_bound;

    always_comb begin
        sh        = SHW'(AW) - SHW'(width_i);
        idx       = (width_i == '0) ? '0 : (rem_i >> sh);
        lim_ext   = {{(AW-LIMW){1'b0}}, limit_i};
        low_bound = (check_i && lower_i) ? lim_ext : '0;
        if (!check_i)
            in_range_o = 1'b1;
        else if (lower_i)
            in_range_o = (idx >= lim_ext);
        else
            in_range_o = (idx <= lim_ext);
        offset_o = idx - low_bound;
    end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int AW    = VA_W,
    parameter int LIMW  = LIM_W,
    parameter int WW    = WID_W,
    parameter int ATTRW = ATTR_W,
    parameter int NLVL  = LEVELS_AFTER_ROOT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [AW-1:0]    logical_addr_i,
    input  logic [AW-1:0]    xlat_ctrl_i,
    input  logic [AW-1:0]    root_w0_i,
    input  logic [AW-1:0]    root_w1_i,
    output logic             mem_req_o,
    output logic [AW-1:0]    mem_addr_o,
    input  logic             mem_rvalid_i,
    input  logic [AW-1:0]    mem_rdata_i,
    output logic             done_o,
    output logic             fault_o,
    output logic [AW-1:0]    paddr_o,
    output logic [ATTRW-1:0] attr_o
);
    localparam int EN_BIT   = AW - 1;
    localparam int IS_LSB   = 16;
    localparam int WID_TOP  = 15;
    localparam int LVLW     = $clog2(NLVL + 1);
    localparam int ROOT_LSB = 4;

    walk_state_e       state_q, state_d;
    logic [AW-1:0]     la_q, rem_q, mask_q, fetch_addr_q, d0_q, d1_q, paddr_q;
    logic [ATTRW-1:0]  attr_acc_q, attr_q;
    logic [WW-1:0]     wid_q [NLVL];
    logic [LVLW-1:0]   lvl_q;
    logic              long_q;

    desc_kind_e        dec_kind, root_kind;
    logic [AW-1:0]     dec_frame, dec_next;
    logic [ATTRW-1:0]  dec_flags;
    logic              dec_lower;
    logic [LIMW-1:0]   dec_lim;

    logic              idle;
    logic [WW-1:0]     init_is, init_w, next_w, ix_w;
    logic [AW-1:0]     init_rem, ix_rem, ix_off, tbl_base, entry_addr;
    logic              ix_chk, ix_lower, ix_in_range, tbl_long, step_ok;
    logic [LIMW-1:0]   ix_lim;
    logic              inputs_unused;

    ptw_desc_decode #(.AW(AW), .LIMW(LIMW), .ATTRW(ATTRW)) u_decode (
        .word0_i     (d0_q),
        .word1_i     (d1_q),
        .long_fmt_i  (long_q),
        .kind_o      (dec_kind),
        .frame_o     (dec_frame),
        .next_tbl_o  (dec_next),
        .flags_o     (dec_flags),
        .lim_lower_o (dec_lower),
        .lim_val_o   (dec_lim)
    );

    ptw_index_unit #(.AW(AW), .LIMW(LIMW), .WW(WW)) u_index (
        .rem_i      (ix_rem),
        .width_i    (ix_w),
        .check_i    (ix_chk),
        .lower_i    (ix_lower),
        .limit_i    (ix_lim),
        .offset_o   (ix_off),
        .in_range_o (ix_in_range)
    );

    // Operand selection: root fields while idle, current descriptor otherwise.
    always_comb begin
        idle      = (state_q == ST_IDLE);
        root_kind = desc_kind_e'(root_w0_i[1:0]);
        init_is   = xlat_ctrl_i[IS_LSB +: WW];
        init_w    = xlat_ctrl_i[WID_TOP -: WW];
        init_rem  = logical_addr_i << init_is;
        next_w    = (lvl_q < LVLW'(NLVL)) ? wid_q[lvl_q] : '0;
        ix_rem    = idle ? init_rem : rem_q;
        ix_w      = idle ? init_w : next_w;
        ix_chk    = idle ? 1'b1 : long_q;
        ix_lower  = idle ? root_w0_i[AW-1] : dec_lower;
        ix_lim    = idle ? root_w0_i[AW-2 -: LIMW] : dec_lim;
        tbl_base  = idle ? {root_w1_i[AW-1:ROOT_LSB], {ROOT_LSB{1'b0}}} : dec_next;
        tbl_long  = idle ? (root_kind == KIND_TBL_LONG) : (dec_kind == KIND_TBL_LONG);
        entry_addr = tbl_base + (tbl_long ? (ix_off << 3) : (ix_off << 2));
        step_ok   = (ix_w != '0) && ix_in_range;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    if (!xlat_ctrl_i[EN_BIT])
                        state_d = ST_DONE;
                    else if (!root_w0_i[1] || !step_ok)
                        state_d = ST_FAULT;
                    else
                        state_d = ST_RD0;
                end
            end
            ST_RD0:    if (mem_rvalid_i) state_d = long_q ? ST_RD1 : ST_DECODE;
            ST_RD1:    if (mem_rvalid_i) state_d = ST_DECODE;
            ST_DECODE: begin
                unique case (dec_kind)
                    KIND_INVALID: state_d = ST_FAULT;
                    KIND_PAGE:    state_d = ST_DONE;
                    default:      state_d = step_ok ? ST_RD0 : ST_FAULT;
                endcase
            end
            ST_DONE:   state_d = ST_IDLE;
            ST_FAULT:  state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Walk datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            la_q         <= '0;
            rem_q        <= '0;
            mask_q       <= '0;
            fetch_addr_q <= '0;
            d0_q         <= '0;
            d1_q         <= '0;
            paddr_q      <= '0;
            attr_acc_q   <= '0;
            attr_q       <= '0;
            lvl_q        <= '0;
            long_q       <= 1'b0;
            for (int k = 0; k < NLVL; k++) wid_q[k] <= '0;
        end else begin
            if (idle && start_i) begin
                la_q         <= logical_addr_i;
                rem_q        <= init_rem << init_w;
                mask_q       <= ({AW{1'b1}} >> init_is) >> init_w;
                attr_acc_q   <= '0;
                lvl_q        <= '0;
                fetch_addr_q <= entry_addr;
                long_q       <= tbl_long;
                for (int k = 0; k < NLVL; k++)
                    wid_q[k] <= xlat_ctrl_i[WID_TOP - WW*(k+1) -: WW];
                if (!xlat_ctrl_i[EN_BIT]) begin
                    paddr_q <= logical_addr_i;
                    attr_q  <= '0;
                end
            end
            if (state_q == ST_RD0 && mem_rvalid_i) begin
                d0_q         <= mem_rdata_i;
                fetch_addr_q <= fetch_addr_q + AW'(4);
            end
            if (state_q == ST_RD1 && mem_rvalid_i)
                d1_q <= mem_rdata_i;
            if (state_q == ST_DECODE) begin
                attr_acc_q <= attr_acc_q | dec_flags;
                if (dec_kind == KIND_PAGE) begin
                    paddr_q <= dec_frame | (la_q & mask_q);
                    attr_q  <= attr_acc_q | dec_flags;
                end else if (dec_kind != KIND_INVALID) begin
                    rem_q        <= rem_q << next_w;
                    mask_q       <= mask_q >> next_w;
                    lvl_q        <= lvl_q + 1'b1;
                    fetch_addr_q <= entry_addr;
                    long_q       <= tbl_long;
                end
            end
        end
    end

    // Outputs
    always_comb begin
        mem_req_o  = (state_q == ST_RD0) || (state_q == ST_RD1);
        mem_addr_o = fetch_addr_q;
        done_o     = (state_q == ST_DONE);
        fault_o    = (state_q == ST_FAULT);
        paddr_o    = paddr_q;
        attr_o     = attr_q;
    end

    assign inputs_unused = ^{xlat_ctrl_i[EN_BIT-1:IS_LSB+WW], root_w0_i[IS_LSB-1:2],
                             root_w1_i[ROOT_LSB-1:0]};
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk
    import ptw_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        start_i,
    input logic [31:0] logical_addr_i,
    input logic [31:0] xlat_ctrl_i,
    input logic [31:0] root_w0_i,
    input logic        mem_req_o,
    input logic [31:0] mem_addr_o,
    input logic        mem_rvalid_i,
    input logic        done_o,
    input logic        fault_o,
    input logic [31:0] paddr_o,
    input walk_state_e state_q,
    input logic        long_q
);
    assert_one_outcome_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && fault_o));

    assert_done_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_fault_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |=> !fault_o);

    assert_result_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (paddr_o != $past(paddr_o)) |-> done_o);

    assert_req_hold_R14: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_rvalid_i) |=> (mem_req_o && $stable(mem_addr_o)));

    assert_bypass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start_i && !xlat_ctrl_i[31])
        |=> (done_o && paddr_o == $past(logical_addr_i)));

    assert_bad_root_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start_i && xlat_ctrl_i[31] && !root_w0_i[1])
        |=> (fault_o && !mem_req_o));

    assert_pair_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RD0 && long_q && mem_rvalid_i)
        |=> (mem_req_o && mem_addr_o == $past(mem_addr_o) + 32'd4));
endmodule

bind ptw_walker ptw_walker_chk u_chk (.*);

// File: tb/tb_ptw_walker.sv
module tb_ptw_walker;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk, rst_n, start;
    logic [31:0] la, ctrl, r0, r1;
    logic        mem_req_o, mem_rvalid;
    logic [31:0] mem_addr_o, mem_rdata;
    logic        done_o, fault_o;
    logic [31:0] paddr_o;
    logic [13:0] attr_o;

    logic [31:0] mem [0:255];
    logic [31:0] exp_q [$];
    logic [31:0] exp_front;
    int n_checks = 0, n_bad = 0, lat = 0, lat_cnt = 0, cycles = 0;

    ptw_walker dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .logical_addr_i(la),
        .xlat_ctrl_i(ctrl), .root_w0_i(r0), .root_w1_i(r1),
        .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
        .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
        .done_o(done_o), .fault_o(fault_o), .paddr_o(paddr_o), .attr_o(attr_o)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            n_checks++;
            n_bad++;
            $display("FAIL watchdog expired actual=%0d expected<%0d", cycles, WATCHDOG);
            $display("test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end

    // Memory model with programmable latency; also compares each read address (R5, R6, R14)
    always @(negedge clk) begin
        if (mem_rvalid) begin
            mem_rvalid <= 1'b0;
            lat_cnt    <= 0;
        end else if (mem_req_o) begin
            if (lat_cnt >= lat) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5 unexpected read", mem_addr_o, 32'h0);
                end else begin
                    exp_front = exp_q.pop_front();
                    check(mem_addr_o == exp_front, "R5/R6 read address", mem_addr_o, exp_front);
                end
                mem_rvalid <= 1'b1;
                mem_rdata  <= mem[mem_addr_o[9:2]];
            end else begin
                lat_cnt <= lat_cnt + 1;
            end
        end
    end

    function automatic logic [31:0] mk_ctrl(input bit en, input int is, input int a,
                                            input int b, input int c, input int d);
        return {en, 7'b0, 4'hC, 4'(is), 4'(a), 4'(b), 4'(c), 4'(d)};
    endfunction

    // Behavioural reference walk
    task automatic ref_walk(input logic [31:0] vla, vctrl, vr0, vr1,
                            output logic [31:0] e_pa, output logic [13:0] e_attr, output bit e_flt);
        int widths [4];
        int w;
        logic [31:0] rem, mask, base, idx, off, addr, d0, d1, lo;
        logic [14:0] limv;
        logic [1:0] typ;
        bit chk, lower;
        widths[0] = int'(vctrl[15:12]);
        widths[1] = int'(vctrl[11:8]);
        widths[2] = int'(vctrl[7:4]);
        widths[3] = int'(vctrl[3:0]);
        exp_q.delete();
        e_pa = 32'h0; e_attr = 14'h0; e_flt = 1'b0;
        if (!vctrl[31]) begin e_pa = vla; return; end
        if (vr0[1:0] < 2) begin e_flt = 1'b1; return; end
        rem   = vla << vctrl[19:16];
        mask  = 32'hFFFF_FFFF >> vctrl[19:16];
        typ   = vr0[1:0];
        base  = vr1 & ~32'hF;
        chk   = 1'b1;
        lower = vr0[31];
        limv  = vr0[30:16];
        for (int lv = 0; lv < 5; lv++) begin
            w = (lv < 4) ? widths[lv] : 0;
            if (w == 0) begin e_flt = 1'b1; return; end
            idx = rem >> (32 - w);
            lo = 0;
            if (chk) begin
                if (lower ? (idx < {17'b0, limv}) : (idx > {17'b0, limv})) begin
                    e_flt = 1'b1; return;
                end
                if (lower) lo = {17'b0, limv};
            end
            off  = idx - lo;
            rem  = rem << w;
            mask = mask >> w;
            addr = base + off * ((typ == 2'd3) ? 8 : 4);
            d0 = mem[addr[9:2]];
            d1 = 32'h0;
            exp_q.push_back(addr);
            if (typ == 2'd3) begin
                d1 = mem[(addr + 4) >> 2];
                exp_q.push_back(addr + 4);
            end
            if (d0[1:0] == 2'd0) begin e_flt = 1'b1; return; end
            if (typ == 2'd3)          e_attr = e_attr | d0[15:2];
            else if (d0[1:0] == 2'd1) e_attr = e_attr | {8'b0, d0[7:2]};
            else                      e_attr = e_attr | {12'b0, d0[3:2]};
            if (d0[1:0] == 2'd1) begin
                e_pa = (((typ == 2'd3) ? d1 : d0) & ~32'hFF) | (vla & mask);
                return;
            end
            base  = ((typ == 2'd3) ? d1 : d0) & ~32'h3;
            chk   = (typ == 2'd3);
            lower = d0[31];
            limv  = d0[30:16];
            typ   = d0[1:0];
        end
        e_flt = 1'b1;
    endtask

    task automatic wait_end(input string tag);
        int n = 0;
        while (!done_o && !fault_o && n < 300) begin
            @(negedge clk);
            n++;
        end
        if (n >= 300) check(1'b0, {tag, " timeout"}, 32'h0, 32'h1);
    endtask

    task automatic run_walk(input string tag, input logic [31:0] vla, vctrl, vr0, vr1);
        logic [31:0] e_pa;
        logic [13:0] e_attr;
        bit e_flt;
        ref_walk(vla, vctrl, vr0, vr1, e_pa, e_attr, e_flt);
        @(negedge clk);
        la = vla; ctrl = vctrl; r0 = vr0; r1 = vr1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_end(tag);
        check(fault_o == e_flt, {tag, " fault flag"}, {31'b0, fault_o}, {31'b0, e_flt});
        check(done_o == !e_flt, {tag, " done flag"}, {31'b0, done_o}, {31'b0, !e_flt});
        if (!e_flt) begin
            check(paddr_o == e_pa, {tag, " paddr"}, paddr_o, e_pa);
            check(attr_o == e_attr, {tag, " attr"}, {18'b0, attr_o}, {18'b0, e_attr});
        end
        check(exp_q.size() == 0, {tag, " reads made"}, exp_q.size(), 32'h0);
        @(negedge clk);
        check(!done_o && !fault_o, {tag, " R13 one-cycle pulse"}, {30'b0, done_o, fault_o}, 32'h0);
    endtask

    initial begin
        logic [31:0] e_pa;
        logic [13:0] e_attr;
        bit e_flt;
        logic [31:0] c2, c3, c1;
        rst_n = 1'b0; start = 1'b0; la = '0; ctrl = '0; r0 = '0; r1 = '0;
        mem_rvalid = 1'b0; mem_rdata = '0;
        for (int i = 0; i < 256; i++) mem[i] = 32'h0;
        // Short-format tables
        mem[32'h04C >> 2] = 32'h0000_0106;   // table -> 0x104, write-protect
        mem[32'h114 >> 2] = 32'h00AB_CD09;   // page, used
        mem[32'h118 >> 2] = 32'h0000_0000;   // invalid
        mem[32'h11C >> 2] = 32'h0000_0182;   // table -> 0x180
        mem[32'h188 >> 2] = 32'h1234_5609;   // page
        // Long-format tables
        mem[32'h218 >> 2] = 32'h0006_000B;   // long table, upper bound 6
        mem[32'h21C >> 2] = 32'h0000_0303;
        mem[32'h220 >> 2] = 32'h000F_0002;   // long desc -> short table
        mem[32'h224 >> 2] = 32'h0000_0380;
        mem[32'h320 >> 2] = 32'h0000_0155;   // long page: WP, M, CI, S
        mem[32'h324 >> 2] = 32'h7654_32FF;
        mem[32'h330 >> 2] = 32'h0000_0009;
        mem[32'h334 >> 2] = 32'h1111_1100;
        mem[32'h384 >> 2] = 32'hCAFE_0005;   // short page
        c2 = mk_ctrl(1, 0, 4, 4, 0, 0);
        c3 = mk_ctrl(1, 4, 4, 4, 4, 0);
        repeat (3) @(negedge clk);
        check(!done_o && !fault_o && !mem_req_o, "R1 outputs in reset",
              {29'b0, done_o, fault_o, mem_req_o}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!done_o && !fault_o && !mem_req_o, "R1 outputs after reset",
              {29'b0, done_o, fault_o, mem_req_o}, 32'h0);
        check(paddr_o == 32'h0 && attr_o == 14'h0, "R1 result regs", paddr_o, 32'h0);

        run_walk("R2 translation off", 32'hDEAD_BEEF, mk_ctrl(0, 0, 4, 4, 0, 0), 32'h000F_0002, 32'h40);
        run_walk("R3 root type 0", 32'h3456_789A, c2, 32'h000F_0000, 32'h40);
        run_walk("R3 root type 1", 32'h3456_789A, c2, 32'h000F_0001, 32'h40);
        run_walk("R7 R11 R12 short two-level", 32'h3456_789A, c2, 32'h000F_0002, 32'h4F);
        lat = 3;
        run_walk("R14 short walk slow memory", 32'h3456_789A, c2, 32'h000F_0002, 32'h4F);
        lat = 0;
        run_walk("R4 upper bound edge", 32'h3456_789A, c2, 32'h0003_0002, 32'h4F);
        run_walk("R4 upper bound exceeded", 32'h4456_789A, c2, 32'h0003_0002, 32'h4F);
        run_walk("R4 lower bound violated", 32'h1000_0000, c2, 32'h8002_0003, 32'h200);
        run_walk("R6 invalid entry", 32'h3556_789A, c2, 32'h000F_0002, 32'h4F);
        run_walk("R10 zero width faults", 32'h3456_789A, mk_ctrl(1, 0, 4, 0, 0, 0), 32'h000F_0002, 32'h4F);
        run_walk("R5 R10 R11 three-level shift", 32'hF362_ABCD, c3, 32'h000F_0002, 32'h4F);
        run_walk("R10 third width zero", 32'hF362_ABCD, mk_ctrl(1, 4, 4, 4, 0, 0), 32'h000F_0002, 32'h4F);
        run_walk("R6 R8 R12 long walk", 32'h5412_3456, c2, 32'h8002_0003, 32'h200);
        lat = 2;
        run_walk("R6 R8 long to short", 32'h61AB_CDEF, c2, 32'h8002_0003, 32'h200);
        lat = 0;
        run_walk("R9 long bound edge", 32'h5600_0000, c2, 32'h8002_0003, 32'h200);
        run_walk("R9 long bound exceeded", 32'h5900_0000, c2, 32'h8002_0003, 32'h200);
        run_walk("R5 root A width zero", 32'h3456_789A, mk_ctrl(1, 0, 0, 4, 0, 0), 32'h000F_0002, 32'h4F);

        // R13: start while busy and start during the completion cycle are both lost
        lat = 4;
        ref_walk(32'h5412_3456, c2, 32'h8002_0003, 32'h200, e_pa, e_attr, e_flt);
        @(negedge clk);
        la = 32'h5412_3456; ctrl = c2; r0 = 32'h8002_0003; r1 = 32'h200; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        la = 32'h3456_789A; r0 = 32'h000F_0002; r1 = 32'h4F; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_end("R13 busy start");
        check(done_o, "R13 busy start done", {31'b0, done_o}, 32'h1);
        check(paddr_o == e_pa, "R13 busy start paddr", paddr_o, e_pa);
        check(attr_o == e_attr, "R13 busy start attr", {18'b0, attr_o}, {18'b0, e_attr});
        c1 = paddr_o;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(!done_o && !fault_o && !mem_req_o, "R13 start in done cycle ignored",
              {29'b0, done_o, fault_o, mem_req_o}, 32'h0);
        repeat (4) @(negedge clk);
        check(!mem_req_o && !done_o && !fault_o, "R13 no walk after done-cycle start",
              {29'b0, done_o, fault_o, mem_req_o}, 32'h0);
        check(paddr_o == c1, "R13 result held", paddr_o, c1);
        lat = 0;

        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end
endmodule